// File: doc/BRIEF.md
# Four-Phase Handshake Datapath Wrapper

This block is the control wrapper around a computation unit that sits between two channels. Both channels use four-phase request/acknowledge signalling. An upstream sender raises a request together with an operand. The wrapper starts the computation unit and waits for its completion flag. It then offers the result downstream and waits for the receiver to acknowledge. Only after that does it acknowledge the sender. Every event in both the evaluation phase and the return-to-zero phase is serialized into one fixed chain: upstream request, start, done, downstream request, downstream acknowledge, upstream acknowledge.

The controller is a Moore machine clocked by the system clock, with one state for each awaited input event. Each handshake output therefore moves only on a state transition, one clock edge after the event it answers. A small register stage latches the operand when a request is accepted. It latches the result when completion is seen, and keeps that result on the output until a later completion.

Top module: `hsw_wrap`

## Requirements
- R1: After reset, start, reqOut and ackIn are all 0. They stay 0 for as long as reqIn stays 0.
- R2: From idle, start goes to 1 one clock edge after reqIn is sampled at 1.
- R3: While start is 1 and reqOut is 0, reqOut goes to 1 one edge after done is sampled at 1. On that same edge dataOut takes the value on resIn.
- R4: While reqOut is 1 and ackIn is 0, ackIn goes to 1 one edge after ackOut is sampled at 1.
- R5: Once ackIn is 1, start returns to 0 one edge after reqIn is sampled at 0.
- R6: Once start has fallen, reqOut returns to 0 one edge after done is sampled at 0.
- R7: Once reqOut has fallen, ackIn returns to 0 one edge after ackOut is sampled at 0. The block is then idle and accepts a new request.
- R8: dataOut does not change from the rise of reqOut until the next time done is accepted. In particular, it holds through the fall of ackOut.
- R9: opData takes dataIn on the edge where the request is accepted. It keeps that value until the next accepted request, even if dataIn changes after ackIn rises.
- R10: An input that is not the awaited event has no effect on the outputs. For example, ackOut pulsing while the datapath is still running leaves reqOut and ackIn at 0.
- R11: Across any sequence of transfers with arbitrary delays, the six handshake wires toggle strictly in the cyclic order reqIn, start, done, reqOut, ackOut, ackIn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqIn | input | 1 | Upstream request |
| dataIn | input | DATA_W | Upstream operand, held by the sender until ackIn rises |
| ackIn | output | 1 | Upstream acknowledge |
| start | output | 1 | Start/reset command to the datapath |
| opData | output | DATA_W | Latched operand presented to the datapath |
| done | input | 1 | Datapath completion flag |
| resIn | input | RES_W | Datapath result, valid while done is 1 |
| reqOut | output | 1 | Downstream request |
| dataOut | output | RES_W | Result offered downstream |
| ackOut | input | 1 | Downstream acknowledge |

## Verification
Every handshake output and both data registers answer their triggering input exactly one clock edge later, because the outputs are decoded from the state register and the registers load on the same edge. The bench drives inputs just after a falling edge, lets one rising edge pass, and samples at the next falling edge. That is where each R2 to R7 result first appears. Stability checks for R8, R9 and R10 hold a wrong or early input for several such edges and sample after each one. The random-delay stream checks ordering at every rising edge. This lets it see the order of events even when a reacting stimulus lands in the same half cycle as the output it follows.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  // One state per awaited input event
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,  // wait reqIn rise
    ST_RUN    = 3'd1,  // wait done rise
    ST_OFFER  = 3'd2,  // wait ackOut rise
    ST_GRANT  = 3'd3,  // wait reqIn fall
    ST_DROP   = 3'd4,  // wait done fall
    ST_RETIRE = 3'd5   // wait ackOut fall
  } hswState_e;

  // Load strobes from control to datapath registers
  typedef struct packed {
    logic loadOp;
    logic loadRes;
  } hswStrobe_t;

endpackage

// File: rtl/hsw_ctrl.sv
module hsw_ctrl
  import hsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqIn,
  input  logic       done,
  input  logic       ackOut,
  output logic       start,
  output logic       reqOut,
  output logic       ackIn,
  output hswStrobe_t strobe
);

  hswState_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (reqIn)   stateNext = ST_RUN;
      ST_RUN:    if (done)    stateNext = ST_OFFER;
      ST_OFFER:  if (ackOut)  stateNext = ST_GRANT;
      ST_GRANT:  if (!reqIn)  stateNext = ST_DROP;
      ST_DROP:   if (!done)   stateNext = ST_RETIRE;
      ST_RETIRE: if (!ackOut) stateNext = ST_IDLE;
      default:                stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  // Moore outputs decoded from the state register only
  assign start  = (state == ST_RUN)   || (state == ST_OFFER) || (state == ST_GRANT);
  assign reqOut = (state == ST_OFFER) || (state == ST_GRANT) || (state == ST_DROP);
  assign ackIn  = (state == ST_GRANT) || (state == ST_DROP)  || (state == ST_RETIRE);

  assign strobe.loadOp  = (state == ST_IDLE) && reqIn;
  assign strobe.loadRes = (state == ST_RUN)  && done;

  // Ordering guards: each output edge follows its predecessor event
  AST_START_RISE:  assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) |-> $past(reqIn) && !ackIn);                      // R2
  AST_REQOUT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reqOut) |-> $past(done) && start);                       // R3
  AST_ACKIN_RISE:  assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ackIn) |-> $past(ackOut) && reqOut && start);            // R4
  AST_START_FALL:  assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start) |-> !$past(reqIn) && ackIn && reqOut);            // R5
  AST_REQOUT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reqOut) |-> !$past(done) && !start && ackIn);            // R6
  AST_ACKIN_FALL:  assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ackIn) |-> !$past(ackOut) && !reqOut && !start);         // R7
  AST_ONE_EDGE:    assert property (@(posedge clk) disable iff (!rst_n)
    $countones({start ^ $past(start), reqOut ^ $past(reqOut),
                ackIn ^ $past(ackIn)}) <= 1);                      // R11

endmodule

// File: rtl/hsw_regs.sv
module hsw_regs
  import hsw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RES_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hswStrobe_t        strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [RES_W-1:0]  resIn,
  output logic [DATA_W-1:0] opData,
  output logic [RES_W-1:0]  dataOut
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             opData <= '0;
    else if (strobe.loadOp) opData <= dataIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              dataOut <= '0;
    else if (strobe.loadRes) dataOut <= resIn;
  end

  AST_OP_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe.loadOp) |-> $stable(opData));                    // R9
  AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.loadOp && strobe.loadRes));                           // R3

endmodule

// File: rtl/hsw_wrap.sv
module hsw_wrap
  import hsw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RES_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              ackIn,
  output logic              start,
  output logic [DATA_W-1:0] opData,
  input  logic              done,
  input  logic [RES_W-1:0]  resIn,
  output logic              reqOut,
  output logic [RES_W-1:0]  dataOut,
  input  logic              ackOut
);

  hswStrobe_t strobe;

  hsw_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .reqIn  (reqIn),
    .done   (done),
    .ackOut (ackOut),
    .start  (start),
    .reqOut (reqOut),
    .ackIn  (ackIn),
    .strobe (strobe)
  );

  hsw_regs #(.DATA_W(DATA_W), .RES_W(RES_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .resIn   (resIn),
    .opData  (opData),
    .dataOut (dataOut)
  );

  // Offered result never moves while downstream may be reading it
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reqOut) || $past(ackIn)) |-> $stable(dataOut));          // R8

endmodule

// File: tb/hsw_wrap_test.sv
`timescale 1ns/1ps
module hsw_wrap_test;

  localparam int DATA_W = 8;
  localparam int RES_W  = 8;
  localparam int LAT    = 2;
  localparam int NXFER  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqIn = 1'b0, done = 1'b0, ackOut = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [RES_W-1:0]  resIn = '0;
  logic ackIn, start, reqOut;
  logic [DATA_W-1:0] opData;
  logic [RES_W-1:0]  dataOut;

  int nChecks = 0;
  int nFails  = 0;
  bit reported = 1'b0;

  always #2.5 clk = ~clk;

  hsw_wrap #(.DATA_W(DATA_W), .RES_W(RES_W)) uut (
    .clk(clk), .rst_n(rst_n), .reqIn(reqIn), .dataIn(dataIn), .ackIn(ackIn),
    .start(start), .opData(opData), .done(done), .resIn(resIn),
    .reqOut(reqOut), .dataOut(dataOut), .ackOut(ackOut)
  );

  function automatic logic [RES_W-1:0] calc(input logic [DATA_W-1:0] x);
    return RES_W'(x * 3 + 5);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // Event-order monitor (R11): the six wires must toggle in cyclic order
  bit monOn = 1'b0;
  int evIdx = 0;
  logic [5:0] prevSig = '0;
  always @(posedge clk) begin
    if (monOn) begin
      logic [5:0] cur, mask;
      cur  = {ackIn, ackOut, reqOut, done, start, reqIn};
      mask = cur ^ prevSig;
      prevSig = cur;
      if (mask != 0) begin
        for (int k = 0; k < 6; k++) begin
          if (mask[evIdx]) begin
            mask[evIdx] = 1'b0;
            evIdx = (evIdx + 1) % 6;
          end
        end
        check("R11 order", int'(mask), 0);
      end
    end
  end

  task automatic t_reset();
    tick();
    check("R1 start", start, 0);
    check("R1 reqOut", reqOut, 0);
    check("R1 ackIn", ackIn, 0);
    repeat (4) tick();
    check("R1 idle start", start, 0);
    check("R1 idle ackIn", ackIn, 0);
  endtask

  task automatic t_stepwise(input logic [7:0] a, input logic [7:0] b);
    dataIn = a; reqIn = 1'b1; tick();
    check("R2 start rise", start, 1);
    check("R9 operand", opData, a);
    check("R2 reqOut low", reqOut, 0);
    ackOut = 1'b1;
    repeat (3) begin
      tick();
      check("R10 early ackOut reqOut", reqOut, 0);
      check("R10 early ackOut ackIn", ackIn, 0);
      check("R10 start kept", start, 1);
    end
    ackOut = 1'b0;
    resIn = b; done = 1'b1; tick();
    check("R3 reqOut rise", reqOut, 1);
    check("R3 dataOut", dataOut, b);
    resIn = ~b; repeat (2) tick();
    check("R8 result held", dataOut, b);
    check("R10 ackIn waits", ackIn, 0);
    ackOut = 1'b1; tick();
    check("R4 ackIn rise", ackIn, 1);
    dataIn = ~a; reqIn = 1'b0; tick();
    check("R5 start fall", start, 0);
    check("R9 operand kept", opData, a);
    check("R5 reqOut kept", reqOut, 1);
    done = 1'b0; tick();
    check("R6 reqOut fall", reqOut, 0);
    check("R8 result after drop", dataOut, b);
    ackOut = 1'b0; tick();
    check("R7 ackIn fall", ackIn, 0);
    check("R8 result after ackOut fall", dataOut, b);
    tick();
    check("R7 idle start", start, 0);
  endtask

  task automatic t_stream();
    logic [DATA_W-1:0] sent [NXFER];
    prevSig = {ackIn, ackOut, reqOut, done, start, reqIn};
    evIdx = 0;
    monOn = 1'b1;
    fork
      begin : upstream
        for (int i = 0; i < NXFER; i++) begin
          repeat ($urandom_range(0, 3)) tick();
          sent[i] = DATA_W'($urandom);
          dataIn = sent[i]; reqIn = 1'b1;
          while (ackIn !== 1'b1) tick();
          dataIn = DATA_W'($urandom);
          repeat ($urandom_range(0, 3)) tick();
          reqIn = 1'b0;
          while (ackIn !== 1'b0) tick();
        end
      end
      begin : datapath_stub
        for (int i = 0; i < NXFER; i++) begin
          while (start !== 1'b1) tick();
          repeat (LAT) tick();
          resIn = calc(opData); done = 1'b1;
          while (start !== 1'b0) tick();
          repeat (LAT) tick();
          done = 1'b0;
        end
      end
      begin : downstream
        for (int i = 0; i < NXFER; i++) begin
          while (reqOut !== 1'b1) tick();
          repeat ($urandom_range(0, 4)) tick();
          check("R3 stream result", dataOut, calc(sent[i]));
          ackOut = 1'b1;
          while (reqOut !== 1'b0) tick();
          repeat ($urandom_range(0, 4)) tick();
          check("R8 stream hold", dataOut, calc(sent[i]));
          ackOut = 1'b0;
        end
      end
    join
    repeat (3) tick();
    monOn = 1'b0;
    check("R11 cycle complete", evIdx, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stepwise(8'h3C, 8'hA5);
    t_stepwise(8'hFF, 8'h00);
    t_stream();
    report();
  end

endmodule